// File: doc/BRIEF.md
# Shift, Rotate and Funnel-Shift Execution Unit

This unit is the shifter slice of an integer execution pipeline. It handles 8-, 16- and 32-bit operands and offers plain rotates, rotates that pass through the carry bit, logical and arithmetic shifts, and funnel (double-precision) shifts. A funnel shift draws the incoming bits from a second operand.

Each request carries operand `opa`, a second operand `opb` that only the funnel shifts read, a shift amount, a carry input, an operand size and a four-bit function code. All of it is sampled on a clock edge while `in_valid` is high. The result and carry-out are computed combinationally by three width-specific lanes. They are registered once, and `out_valid` marks the cycle in which they appear.

Top module: `shift_rotate_unit`

## Requirements
- R1: Function code 0 rotates `opa` left and code 1 rotates it right. Only the low 3, 4 or 5 bits of `shamt` count, for 8-, 16- or 32-bit size.
- R2: Codes 2 (left) and 3 (right) rotate through carry as a 9-, 17- or 33-bit ring made of the carry bit and the operand. They use `shamt[4:0]`, reduced modulo width+1.
- R3: Code 4 shifts left and code 5 shifts right logically, filling with zeros. Code 6 behaves exactly like code 4. The amount is masked as in R1.
- R4: Code 7 shifts right arithmetically. Vacated positions take copies of the operand's original top bit. The amount is masked as in R1.
- R5: Code 8 is a funnel left shift. `opb` is placed below `opa`, the pair is shifted left by `shamt[4:0]` with zeros entering from below, and the upper half is returned. For a 32-bit size, `opa`=0x01234567, `opb`=0x89ABCDEF and an amount of 4 give 0x12345678.
- R6: Code 9 is a funnel right shift. `opb` is placed above `opa`, the pair is shifted right by `shamt[4:0]` with zeros entering from above, and the lower half is returned. The same operands as in R5 give 0xF0123456.
- R7: `carry_out` is the last bit moved out of the operand, or for codes 2 and 3 the carry position after rotation. When the effective amount is 0, the result equals `opa` and `carry_out` equals `carry_in`.
- R8: `size` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 selects 32 bits. Operand bits above the selected width are ignored, and result bits above it read as zero.
- R9: `result`, `carry_out` and `out_valid` are registered. They update on the clock edge where `in_valid` is high and hold their values otherwise. `out_valid` is high exactly in the cycle after an accepted request.
- R10: While `rst_n` is low, `out_valid`, `result` and `carry_out` are all zero.
- R11: Codes 10 to 15 return `opa` (masked to the size) with `carry_out` equal to `carry_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 4 | Function code |
| size | input | 2 | Operand size select |
| opa | input | 32 | Operand shifted, rotated or funnelled |
| opb | input | 32 | Funnel fill operand |
| shamt | input | 8 | Shift or rotate amount |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result registered for the accepted request |
| result | output | 32 | Operation result, zero above the width |
| carry_out | output | 1 | Outgoing carry flag |

## Verification
Each request's result and carry-out are due one clock edge after the edge that accepted it. No cycle is hidden: the lanes are combinational and the single register stage feeds the ports directly. The bench drives every request on a falling edge and compares on the next falling edge, which falls between the capturing edge and the following one. Hold checks keep `in_valid` low for two further edges and compare again.

// File: rtl/srd_pkg.sv
package srd_pkg;
  localparam logic [3:0] OP_ROL  = 4'd0;
  localparam logic [3:0] OP_ROR  = 4'd1;
  localparam logic [3:0] OP_RCL  = 4'd2;
  localparam logic [3:0] OP_RCR  = 4'd3;
  localparam logic [3:0] OP_SHL  = 4'd4;
  localparam logic [3:0] OP_SHR  = 4'd5;
  localparam logic [3:0] OP_SHL2 = 4'd6;
  localparam logic [3:0] OP_SAR  = 4'd7;
  localparam logic [3:0] OP_FSL  = 4'd8;
  localparam logic [3:0] OP_FSR  = 4'd9;

  localparam int AMT_W = 5;
endpackage

// File: rtl/srd_lane.sv
module srd_lane
  import srd_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic [3:0]       op,
  input  logic [LW-1:0]    a,
  input  logic [LW-1:0]    b,
  input  logic [AMT_W-1:0] amt,
  input  logic             cin,
  output logic [LW-1:0]    res,
  output logic             cout
);
  localparam int PW = $clog2(LW);
  localparam int RW = LW + 1;

  logic [PW-1:0]       amt_p;
  logic [AMT_W-1:0]    amt_r;
  logic [2*LW-1:0]     rol_w;
  logic [2*LW-1:0]     ror_w;
  logic [2*RW-1:0]     rcl_w;
  logic [2*RW-1:0]     rcr_w;
  logic [LW:0]         shl_w;
  logic [LW:0]         shr_w;
  logic signed [LW:0]  sar_w;
  logic [2*LW+31:0]    fsl_w;
  logic [2*LW:0]       fsr_w;
  logic [LW-1:0]       res_n;
  logic                cout_n;
  logic                zero_amt;

  assign amt_p = amt[PW-1:0];
  assign amt_r = AMT_W'({27'b0, amt} % 32'(RW));

  assign rol_w = {a, a} << amt_p;
  assign ror_w = {a, a} >> amt_p;
  assign rcl_w = {cin, a, cin, a} << amt_r;
  assign rcr_w = {cin, a, cin, a} >> amt_r;
  assign shl_w = {1'b0, a} << amt_p;
  assign shr_w = {a, 1'b0} >> amt_p;
  assign sar_w = $signed({a, 1'b0}) >>> amt_p;
  assign fsl_w = {32'b0, a, b} << amt;
  assign fsr_w = {b, a, 1'b0} >> amt;

  always_comb begin
    res_n    = a;
    cout_n   = cin;
    zero_amt = 1'b1;
    case (op)
      OP_ROL: begin
        res_n = rol_w[2*LW-1:LW]; cout_n = rol_w[LW]; zero_amt = (amt_p == '0);
      end
      OP_ROR: begin
        res_n = ror_w[LW-1:0]; cout_n = ror_w[LW-1]; zero_amt = (amt_p == '0);
      end
      OP_RCL: begin
        res_n = rcl_w[2*RW-2:RW]; cout_n = rcl_w[2*RW-1]; zero_amt = (amt_r == '0);
      end
      OP_RCR: begin
        res_n = rcr_w[LW-1:0]; cout_n = rcr_w[LW]; zero_amt = (amt_r == '0);
      end
      OP_SHL, OP_SHL2: begin
        res_n = shl_w[LW-1:0]; cout_n = shl_w[LW]; zero_amt = (amt_p == '0);
      end
      OP_SHR: begin
        res_n = shr_w[LW:1]; cout_n = shr_w[0]; zero_amt = (amt_p == '0);
      end
      OP_SAR: begin
        res_n = sar_w[LW:1]; cout_n = sar_w[0]; zero_amt = (amt_p == '0);
      end
      OP_FSL: begin
        res_n = fsl_w[2*LW-1:LW]; cout_n = fsl_w[2*LW]; zero_amt = (amt == '0);
      end
      OP_FSR: begin
        res_n = fsr_w[LW:1]; cout_n = fsr_w[0]; zero_amt = (amt == '0);
      end
      default: zero_amt = 1'b1;
    endcase
  end

  assign res  = zero_amt ? a   : res_n;
  assign cout = zero_amt ? cin : cout_n;
endmodule

// File: rtl/srd_select.sv
module srd_select #(
  parameter int NL = 3,
  parameter int DW = 32
) (
  input  logic [1:0]           size,
  input  logic [NL-1:0][DW-1:0] lane_res,
  input  logic [NL-1:0]        lane_c,
  output logic [DW-1:0]        res,
  output logic                 cout
);
  always_comb begin
    res  = lane_res[NL-1];
    cout = lane_c[NL-1];
    for (int i = 0; i < NL - 1; i++) begin
      if (32'(size) == i) begin
        res  = lane_res[i];
        cout = lane_c[i];
      end
    end
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import srd_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [1:0]    size,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [CW-1:0] shamt,
  input  logic          carry_in,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          carry_out
);
  localparam int NL = $clog2(DW / 8) + 1;

  logic [NL-1:0][DW-1:0] lane_res;
  logic [NL-1:0]         lane_c;
  logic [DW-1:0]         sel_res;
  logic                  sel_c;
  logic [AMT_W-1:0]      amt;

  logic [DW-1:0] result_q, result_n;
  logic          carry_q, carry_n;
  logic          valid_q, valid_n;

  assign amt = shamt[AMT_W-1:0];

  for (genvar gi = 0; gi < NL; gi++) begin : g_lane
    localparam int LW = 8 << gi;
    logic [LW-1:0] lres;
    srd_lane #(.LW(LW)) u_lane (
      .op   (op),
      .a    (opa[LW-1:0]),
      .b    (opb[LW-1:0]),
      .amt  (amt),
      .cin  (carry_in),
      .res  (lres),
      .cout (lane_c[gi])
    );
    assign lane_res[gi] = DW'(lres);
  end

  srd_select #(.NL(NL), .DW(DW)) u_select (
    .size     (size),
    .lane_res (lane_res),
    .lane_c   (lane_c),
    .res      (sel_res),
    .cout     (sel_c)
  );

  always_comb begin
    valid_n  = in_valid;
    result_n = result_q;
    carry_n  = carry_q;
    if (in_valid) begin
      result_n = sel_res;
      carry_n  = sel_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      carry_q  <= 1'b0;
    end else begin
      valid_q  <= valid_n;
      result_q <= result_n;
      carry_q  <= carry_n;
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
  assign carry_out = carry_q;

  p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(carry_out)));
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'd0) |=> (result[DW-1:8] == '0));
  p_rot_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'd2 && (op == OP_ROL || op == OP_ROR))
      |=> ($countones(result) == $countones($past(opa))));
  p_rcr_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'd2 && (op == OP_RCL || op == OP_RCR))
      |=> ($countones({carry_out, result}) == $countones({$past(carry_in), $past(opa)})));
  p_sar_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'd2 && op == OP_SAR)
      |=> (result[DW-1] == $past(opa[DW-1])));
endmodule

// File: tb/shift_rotate_unit_bench.sv
`timescale 1ns/1ps
module shift_rotate_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic [1:0]  size;
  logic [31:0] opa, opb;
  logic [7:0]  shamt;
  logic        carry_in;
  logic        out_valid;
  logic [31:0] result;
  logic        carry_out;

  int total = 0;
  int bad   = 0;

  shift_rotate_unit u_shift_rotate_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
    .opa(opa), .opb(opb), .shamt(shamt), .carry_in(carry_in),
    .out_valid(out_valid), .result(result), .carry_out(carry_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int width_of(input logic [1:0] s);
    return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
  endfunction

  function automatic int steps_of(input logic [3:0] f_op, input logic [1:0] s, input logic [7:0] cnt);
    int w = width_of(s);
    if (f_op == 4'd2 || f_op == 4'd3 || f_op == 4'd8 || f_op == 4'd9) return int'(cnt[4:0]);
    if (f_op <= 4'd7) return int'(cnt) & (w - 1);
    return 0;
  endfunction

  // Bit-serial reference: one position per step.
  function automatic logic [32:0] ref_model(input logic [3:0] f_op, input logic [1:0] s,
      input logic [31:0] fa, input logic [31:0] fb, input logic [7:0] cnt, input logic fc);
    int w = width_of(s);
    logic [31:0] m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    logic [31:0] a = fa & m;
    logic [31:0] b = fb & m;
    logic c = fc;
    logic t;
    int n = steps_of(f_op, s, cnt);
    for (int i = 0; i < n; i++) begin
      case (f_op)
        4'd0: begin c = a[w-1]; a = ((a << 1) | 32'(c)) & m; end
        4'd1: begin c = a[0]; a = (a >> 1) | (32'(c) << (w - 1)); end
        4'd2: begin t = a[w-1]; a = ((a << 1) | 32'(c)) & m; c = t; end
        4'd3: begin t = a[0]; a = (a >> 1) | (32'(c) << (w - 1)); c = t; end
        4'd4, 4'd6: begin c = a[w-1]; a = (a << 1) & m; end
        4'd5: begin c = a[0]; a = a >> 1; end
        4'd7: begin c = a[0]; t = a[w-1]; a = (a >> 1) | (32'(t) << (w - 1)); end
        4'd8: begin c = a[w-1]; a = ((a << 1) | 32'(b[w-1])) & m; b = (b << 1) & m; end
        4'd9: begin c = a[0]; a = (a >> 1) | (32'(b[0]) << (w - 1)); b = b >> 1; end
        default: ;
      endcase
    end
    return {c, a};
  endfunction

  function automatic string tag_of(input logic [3:0] f_op, input int n);
    if (f_op > 4'd9) return "R11";
    if (n == 0) return "R7";
    case (f_op)
      4'd0, 4'd1: return "R1";
      4'd2, 4'd3: return "R2";
      4'd7:       return "R4";
      4'd8:       return "R5";
      4'd9:       return "R6";
      default:    return "R3";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got_r, input logic [31:0] exp_r,
                       input logic got_c, input logic exp_c);
    total++;
    if (got_r !== exp_r || got_c !== exp_c) begin
      bad++;
      $display("FAIL %s: got result=%h carry=%b, expected result=%h carry=%b",
               tag, got_r, got_c, exp_r, exp_c);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the capture.
  task automatic apply(input logic [3:0] f_op, input logic [1:0] s, input logic [31:0] fa,
                       input logic [31:0] fb, input logic [7:0] cnt, input logic fc);
    logic [32:0] e;
    int w;
    in_valid = 1'b1; op = f_op; size = s; opa = fa; opb = fb; shamt = cnt; carry_in = fc;
    @(posedge clk);
    @(negedge clk);
    e = ref_model(f_op, s, fa, fb, cnt, fc);
    check(tag_of(f_op, steps_of(f_op, s, cnt)), result, e[31:0], carry_out, e[32]);
    check("R9 valid", {31'b0, out_valid}, 32'd1, 1'b0, 1'b0);
    w = width_of(s);
    if (w < 32) check("R8 upper", result >> w, 32'd0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] held_r;
    logic        held_c;
    int          cl[6];
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; op = '0; size = '0; opa = '0; opb = '0;
    shamt = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset", result, 32'd0, carry_out, 1'b0);
    check("R10 valid", {31'b0, out_valid}, 32'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 / R6 worked example
    apply(4'd8, 2'd2, 32'h0123_4567, 32'h89AB_CDEF, 8'd4, 1'b0);
    check("R5 example", result, 32'h1234_5678, carry_out, 1'b0);
    apply(4'd9, 2'd2, 32'h0123_4567, 32'h89AB_CDEF, 8'd4, 1'b0);
    check("R6 example", result, 32'hF012_3456, carry_out, 1'b0);

    // R9: hold while idle
    held_r = result; held_c = carry_out;
    in_valid = 1'b0; op = 4'd0; opa = 32'hFFFF_0000; shamt = 8'd3; carry_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 hold", result, held_r, carry_out, held_c);
    check("R9 idle valid", {31'b0, out_valid}, 32'd0, 1'b0, 1'b0);

    // R7: zero amounts pass A and carry-in through
    apply(4'd4, 2'd0, 32'h0000_00A5, 32'd0, 8'd8, 1'b1);
    check("R7 zero amount", result, 32'h0000_00A5, carry_out, 1'b1);

    // R3: code 6 equals code 4
    apply(4'd6, 2'd1, 32'h0000_8001, 32'd0, 8'd1, 1'b0);
    check("R3 alias", result, 32'h0000_0002, carry_out, 1'b1);

    // Directed corner sweep over every code, size and key amounts
    for (int o = 0; o < 16; o++) begin
      for (int s = 0; s < 4; s++) begin
        int w = width_of(2'(s));
        cl[0] = 0; cl[1] = 1; cl[2] = w - 1; cl[3] = 31; cl[4] = w; cl[5] = w + 1;
        for (int k = 0; k < 6; k++) begin
          apply(4'(o), 2'(s), $urandom(), $urandom(), 8'(cl[k]), 1'($urandom()));
        end
      end
    end

    // Constrained random requests
    for (int r = 0; r < 3000; r++) begin
      apply(4'($urandom_range(0, 11)), 2'($urandom_range(0, 3)), $urandom(), $urandom(),
            8'($urandom()), 1'($urandom()));
    end

    in_valid = 1'b0;
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule